// File: doc/BRIEF.md
# Packed Lane Arithmetic Unit

This block is a 64-bit datapath that splits each operand into independent lanes and operates on all lanes at once. A lane-size field selects eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The block adds, subtracts, compares and multiplies. No carry or borrow crosses from one lane into the next. Sums and differences either wrap modulo the lane width or clamp at the lane's signed or unsigned limits. Compares return a mask that is all ones or all zeros in each lane. The multiply always works on four signed 16-bit lanes and returns either the lower or the upper half of each 32-bit product.

A host presents two operands, an opcode, a lane size and a saturation mode, together with an input valid strobe. One clock later the result appears on a register, with a matching output valid. This makes the block easy to place as one pipeline stage of a media or signal-processing datapath.

Top module: `simd_alu`

## Requirements
- R1: Reset is synchronous and active high, and clears `res_o` to zero and `res_valid_o` to 0. On the first rising edge after a cycle with `in_valid_i` = 1, `res_o` carries that cycle's result and `res_valid_o` = 1. In a cycle with `in_valid_i` = 0, the next edge leaves `res_o` unchanged and drives `res_valid_o` to 0.
- R2: The lane size `lane_sz_i` is encoded as 0 = 8-bit lanes, 1 = 16-bit lanes, 2 = 32-bit lanes, and 3 behaves exactly as 2. Lane k occupies bits [k*W+W-1 : k*W].
- R3: Opcode 0 adds and opcode 1 subtracts (a minus b) lane by lane. With `sat_i` = 0 or 3 the lane result wraps modulo 2^W, and no carry or borrow reaches any other lane.
- R4: With `sat_i` = 1 (signed saturation), an add or subtract whose true signed result lies above 2^(W-1)-1 yields that maximum. One that lies below -2^(W-1) yields that minimum.
- R5: With `sat_i` = 2 (unsigned saturation), an add whose true result exceeds 2^W-1 yields all ones in the lane. A subtract whose true result is negative yields zero.
- R6: Opcode 2 (equal) sets a lane to all ones when the two lanes are bit-identical, and to all zeros otherwise.
- R7: Opcode 3 (greater) sets a lane to all ones when the lane of a is greater than the lane of b, both taken as signed two's complement. Otherwise it sets the lane to all zeros.
- R8: Opcode 4 multiplies four 16-bit lanes and returns bits [15:0] of each product. `lane_sz_i` and `sat_i` have no effect on multiplies.
- R9: Opcode 5 multiplies four signed 16-bit lanes and returns bits [31:16] of each 32-bit signed product.
- R10: Opcodes 6 and 7 produce a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and controls are valid this cycle |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b |
| op_i | input | 3 | Opcode (0 add, 1 sub, 2 eq, 3 gt, 4 mul low, 5 mul high) |
| lane_sz_i | input | 2 | Lane size select |
| sat_i | input | 2 | Saturation mode (0/3 wrap, 1 signed, 2 unsigned) |
| res_valid_o | output | 1 | Result register holds a new result |
| res_o | output | 64 | Registered result |

## Verification
Several properties are checked on every cycle. The output valid follows the input strobe with one cycle of delay, and the result register holds its value across idle cycles. Every 8-bit compare lane is a clean 00 or FF mask. A greater-than on equal operands gives zero. An unsigned saturating byte add never returns a lane smaller than its first operand. Only the bench scenarios show the arithmetic values themselves: that carries stop at the boundaries for each lane size, where each clamp lands, and the signed high halves of products. The bench compares every result against a lane model written from the requirements.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W  = 64;
  localparam int BASE_W  = 8;
  localparam int NSIZE   = 3;
  localparam int MUL_W   = 16;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_EQ    = 3'd2,
    OP_GT    = 3'd3,
    OP_MULLO = 3'd4,
    OP_MULHI = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SAT_WRAP  = 2'd0,
    SAT_SIGN  = 2'd1,
    SAT_UNS   = 2'd2,
    SAT_WRAP3 = 2'd3
  } sat_e;

  function automatic logic [1:0] size_index(input logic [1:0] lsz);
    return (lsz >= 2'd2) ? 2'd2 : lsz;
  endfunction
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BASE_W,
  parameter int NS = NSIZE
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic [1:0]    lane_sz_i,
  input  sat_e          sat_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] per_size [NS];

  for (genvar s = 0; s < NS; s++) begin : g_size
    localparam int W  = BW << s;
    localparam int NL = DW / W;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [W-1:0] a_l, b_l, r_l;
      logic [W:0]   ext;
      logic         ovf_s;
      assign a_l = a_i[l*W +: W];
      assign b_l = b_i[l*W +: W];
      assign ext = sub_i ? ({1'b0, a_l} - {1'b0, b_l})
                         : ({1'b0, a_l} + {1'b0, b_l});
      assign ovf_s = (sub_i ? (a_l[W-1] != b_l[W-1]) : (a_l[W-1] == b_l[W-1]))
                     && (ext[W-1] != a_l[W-1]);
      always_comb begin
        unique case (sat_i)
          SAT_SIGN: begin
            if (ovf_s) r_l = a_l[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            else       r_l = ext[W-1:0];
          end
          SAT_UNS: begin
            if (ext[W]) r_l = sub_i ? {W{1'b0}} : {W{1'b1}};
            else        r_l = ext[W-1:0];
          end
          default: r_l = ext[W-1:0];
        endcase
      end
      assign per_size[s][l*W +: W] = r_l;
    end
  end

  assign y_o = per_size[size_index(lane_sz_i)];
endmodule

// File: rtl/simd_cmp.sv
module simd_cmp
  import simd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BASE_W,
  parameter int NS = NSIZE
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          gt_i,
  input  logic [1:0]    lane_sz_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] per_size [NS];

  for (genvar s = 0; s < NS; s++) begin : g_size
    localparam int W  = BW << s;
    localparam int NL = DW / W;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [W-1:0] a_l, b_l;
      logic         hit;
      assign a_l = a_i[l*W +: W];
      assign b_l = b_i[l*W +: W];
      assign hit = gt_i ? ($signed(a_l) > $signed(b_l)) : (a_l == b_l);
      assign per_size[s][l*W +: W] = {W{hit}};
    end
  end

  assign y_o = per_size[size_index(lane_sz_i)];
endmodule

// File: rtl/simd_mul.sv
module simd_mul
  import simd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int MW = MUL_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          hi_i,
  output logic [DW-1:0] y_o
);
  localparam int NL = DW / MW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic signed [MW-1:0]   a_l, b_l;
    logic signed [2*MW-1:0] prod;
    assign a_l  = a_i[l*MW +: MW];
    assign b_l  = b_i[l*MW +: MW];
    assign prod = a_l * b_l;
    assign y_o[l*MW +: MW] = hi_i ? prod[2*MW-1:MW] : prod[MW-1:0];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_sz_i,
  input  logic [1:0]        sat_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_o
);
  op_e               op;
  logic [DATA_W-1:0] as_y, cmp_y, mul_y, nxt;

  assign op = op_e'(op_i);

  simd_addsub #(.DW(DATA_W), .BW(BASE_W), .NS(NSIZE)) u_addsub (
    .a_i(opa_i), .b_i(opb_i), .sub_i(op == OP_SUB),
    .lane_sz_i(lane_sz_i), .sat_i(sat_e'(sat_i)), .y_o(as_y));

  simd_cmp #(.DW(DATA_W), .BW(BASE_W), .NS(NSIZE)) u_cmp (
    .a_i(opa_i), .b_i(opb_i), .gt_i(op == OP_GT),
    .lane_sz_i(lane_sz_i), .y_o(cmp_y));

  simd_mul #(.DW(DATA_W), .MW(MUL_W)) u_mul (
    .a_i(opa_i), .b_i(opb_i), .hi_i(op == OP_MULHI), .y_o(mul_y));

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:     nxt = as_y;
      OP_EQ, OP_GT:       nxt = cmp_y;
      OP_MULLO, OP_MULHI: nxt = mul_y;
      default:            nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) res_o <= nxt;
    end
  end

  // R1: output valid tracks input strobe one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> res_valid_o);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !res_valid_o);
  // R1: idle cycles keep the result register
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(res_o));
  // R7: signed greater on identical operands is never true
  a_r7_gt_equal_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i == 3'd3 && opa_i == opb_i) |=> (res_o == '0));

  for (genvar k = 0; k < DATA_W / BASE_W; k++) begin : g_chk
    // R6: byte compare lanes are clean masks
    a_r6_byte_mask: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && (op_i == 3'd2 || op_i == 3'd3) && lane_sz_i == 2'd0)
      |=> (res_o[k*BASE_W +: BASE_W] == '0 || res_o[k*BASE_W +: BASE_W] == '1));
    // R5: unsigned saturating byte add never falls below operand a
    a_r5_usat_floor: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && op_i == 3'd0 && lane_sz_i == 2'd0 && sat_i == 2'd2)
      |=> (res_o[k*BASE_W +: BASE_W] >= $past(opa_i[k*BASE_W +: BASE_W])));
  end
endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [2:0]  op = '0;
  logic [1:0]  lsz = '0, sat = '0;
  logic        res_valid;
  logic [63:0] res;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t sb[$];
  logic [63:0] last_exp = '0;

  simd_alu i_simd_alu (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .opa_i(opa), .opb_i(opb),
    .op_i(op), .lane_sz_i(lsz), .sat_i(sat),
    .res_valid_o(res_valid), .res_o(res));

  always #4 clk = ~clk;

  function automatic logic [63:0] model(input logic [2:0] o, input logic [1:0] ls,
                                        input logic [1:0] sm, input logic [63:0] a,
                                        input logic [63:0] b);
    int    w;
    longint mask, half, ua, ub, sa, sb2, u, s, r;
    logic [63:0] out;
    out = '0;
    if (o >= 3'd6) return '0;
    w = (o >= 3'd4) ? 16 : (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    for (int l = 0; l < 64 / w; l++) begin
      ua = longint'((a >> (l * w))) & mask;
      ub = longint'((b >> (l * w))) & mask;
      sa = (ua >= half) ? ua - (mask + 1) : ua;
      sb2 = (ub >= half) ? ub - (mask + 1) : ub;
      case (o)
        3'd0, 3'd1: begin
          u = (o == 3'd0) ? ua + ub : ua - ub;
          s = (o == 3'd0) ? sa + sb2 : sa - sb2;
          if (sm == 2'd1) begin
            if (s > half - 1) s = half - 1;
            if (s < -half) s = -half;
            r = s & mask;
          end else if (sm == 2'd2) begin
            if (u > mask) u = mask;
            if (u < 0) u = 0;
            r = u;
          end else r = u & mask;
        end
        3'd2: r = (ua == ub) ? mask : 0;
        3'd3: r = (sa > sb2) ? mask : 0;
        3'd4: r = (sa * sb2) & mask;
        default: r = ((sa * sb2) >>> 16) & mask;
      endcase
      out = out | (64'(r) << (l * w));
    end
    return out;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [1:0] ls, input logic [1:0] sm,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(negedge clk);
    op = o; lsz = ls; sat = sm; opa = a; opb = b; in_valid = 1'b1;
    it.exp = model(o, ls, sm, a, b);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_eq(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result is flagged
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: unexpected valid, got %h expected none", res);
      end else begin
        item_t it;
        it = sb.pop_front();
        expect_eq(res, it.exp, it.tag);
        last_exp = it.exp;
      end
    end
  end

  function automatic string tag_of(input logic [2:0] o, input logic [1:0] sm);
    case (o)
      3'd0, 3'd1: return (sm == 2'd1) ? "R4" : (sm == 2'd2) ? "R5" : "R3";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_eq({63'd0, res_valid}, 64'd0, "R1 reset valid");
    expect_eq(res, 64'd0, "R1 reset result");
    rst = 1'b0;

    // R3: wrap add/sub, carry stops at every lane size
    drive(3'd0, 2'd0, 2'd0, 64'h00FF_00FF_7F80_01FF, 64'h0001_0001_0180_0101, "R3 add8");
    drive(3'd0, 2'd1, 2'd0, 64'h0000_FFFF_1234_FFFF, 64'h0000_0001_1111_0002, "R3 add16");
    drive(3'd0, 2'd2, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3 add32");
    drive(3'd1, 2'd0, 2'd0, 64'h0500_0500_0500_0500, 64'h0101_0101_0101_0101, "R3 sub8");
    drive(3'd1, 2'd1, 2'd3, 64'h0000_0005_0000_0000, 64'h0001_0006_0000_0001, "R3 sub16 mode3");
    // R2: size code 3 acts as 32-bit lanes
    drive(3'd0, 2'd3, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R2 size3");
    // R4: signed saturation
    drive(3'd0, 2'd0, 2'd1, 64'h7F80_7F80_0102_7FFF, 64'h01FF_7F80_0304_0101, "R4 add8");
    drive(3'd1, 2'd1, 2'd1, 64'h8000_7FFF_0010_8000, 64'h0001_FFFF_0020_7FFF, "R4 sub16");
    drive(3'd0, 2'd2, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, "R4 add32");
    // R5: unsigned saturation
    drive(3'd0, 2'd0, 2'd2, 64'hFF80_1020_FFFF_0001, 64'h0181_1020_0102_0001, "R5 add8");
    drive(3'd1, 2'd0, 2'd2, 64'h0080_1020_0001_0300, 64'h0181_0530_0200_0101, "R5 sub8");
    drive(3'd1, 2'd2, 2'd2, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001, "R5 sub32");
    // R6 / R7: compare masks
    drive(3'd2, 2'd0, 2'd0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R6 eq8");
    drive(3'd2, 2'd2, 2'd0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0000, "R6 eq32");
    drive(3'd3, 2'd0, 2'd0, 64'h7F80_0102_FF00_0505, 64'h807F_0201_00FF_0505, "R7 gt8");
    drive(3'd3, 2'd1, 2'd0, 64'h8000_0001_FFFF_1234, 64'h7FFF_0000_0000_1234, "R7 gt16");
    // R8 / R9: multiply, lane size and saturation ignored
    drive(3'd4, 2'd0, 2'd1, 64'hFFFF_7FFF_0100_1234, 64'h0002_7FFF_0100_0010, "R8 mullo");
    drive(3'd5, 2'd2, 2'd0, 64'hFFFF_7FFF_8000_1234, 64'h0002_7FFF_8000_0010, "R9 mulhi");
    // R10: reserved opcodes
    drive(3'd6, 2'd0, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R10 op6");
    drive(3'd7, 2'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, "R10 op7");

    for (int i = 0; i < 300; i++) begin
      logic [2:0] o;
      logic [1:0] s;
      o = 3'($urandom_range(0, 7));
      s = 2'($urandom_range(0, 3));
      drive(o, 2'($urandom_range(0, 3)), s, {$urandom, $urandom}, {$urandom, $urandom},
            tag_of(o, s));
    end

    // R1: idle cycles hold the last result and drop valid
    idle();
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
    expect_eq(res, last_exp, "R1 hold");
    expect_eq({63'd0, res_valid}, 64'd0, "R1 valid low");

    finish_run();
  end
endmodule